// File: doc/BRIEF.md
# Programmable COM Port Address Decoder

This block lets firmware choose which standard COM port address a host-side UART-mimic answers at, so no jumpers are needed. It watches host address bits 9 down to 3 and the host address-enable line. When decoding is enabled and the address falls on the programmed port base during an ordinary host cycle, it raises an internal select for the mimic registers. When decoding is disabled, the select instead follows the external active-low chip-select input.

The same configuration steers the mimic interrupt onto one of two host interrupt pins and releases the other pin to high impedance. A force option drives an active-low chip-select output for external logic during a matching read or write. Cycles with address-enable high belong to the DMA mailbox space and never produce a select.

The local CPU writes a small configuration register. Reading that register also returns the two COM-select status pins, after they pass through a synchronizer.

Top module: `com_addr_decoder`

## Requirements
- R1: The internal select rises only when decoding is enabled (configuration bit 0 = 1), address-enable is low and address bits 9..3 equal bits 9..3 of the chosen base. The chosen base is set by configuration bits 4:3: 0 selects 0x3F8, 1 selects 0x2F8, 2 selects 0x3E8 and 3 selects 0x2E8.
- R2: While decoding is enabled, the external chip-select input has no effect on the internal select. While decoding is disabled, the internal select equals the inverse of that input.
- R3: The chip-select output goes low only when decoding is enabled, the force bit (configuration bit 1) is 1, the address matches as in R1, and host read or host write is low. Otherwise it stays high.
- R4: While address-enable is high (a mailbox access), neither the chip-select output nor the decoded internal select is asserted.
- R5: With decoding enabled, ports 0 and 2 drive interrupt pin 1 and ports 1 and 3 drive interrupt pin 2. With decoding disabled, pin 1 is driven. Exactly one output enable is high at a time. The driven pin carries the mimic interrupt, and an undriven pin outputs 0 with its enable low.
- R6: After reset the configuration reads 0x00, so decoding is disabled and the force bit is clear.
- R7: Configuration read-back bits 6:5 show the COM-select pins, delayed by SYNC_STAGES clock edges. Bits 4:3 read back the port, bit 1 the force bit and bit 0 the enable.
- R8: A configuration write takes effect at the next clock edge and the value holds while no write occurs. Written bits 2, 5, 6 and 7 are discarded, and bits 7 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 7 | Host address bits 9..3 |
| host_aen | input | 1 | Host address-enable, high for mailbox/DMA cycles |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| ext_cs_n | input | 1 | External chip select, used when decoding is disabled |
| com_pins | input | 2 | COM-select status pins |
| mimic_irq | input | 1 | Interrupt request from the UART mimic |
| cfg_we | input | 1 | Configuration write enable from the local CPU |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back including pin status |
| mimic_sel | output | 1 | Internal select for the mimic registers |
| cs_out_n | output | 1 | Forced chip-select output, active low |
| hint_o | output | 2 | Host interrupt pin values |
| hint_oe | output | 2 | Host interrupt pin output enables |

## Verification
The two functions that can fall in the same cycle are a configuration write and a live host access that depends on that configuration. The bench provokes this by writing a new port and force setting in the same cycle that a host read or write is active on the old port's base. A reference model applies the new setting only from the following clock. Comparing on every clock therefore catches both a write that takes effect too early and one that is lost. Readback of the status pins is also checked while they toggle across a configuration write.

// File: rtl/comdec_pkg.sv
package comdec_pkg;

  typedef struct packed {
    logic [1:0] port;
    logic       force_cs;
    logic       dec_en;
  } comdec_cfg_t;

  localparam int CFG_W  = 8;
  localparam int PIN_W  = 2;
  localparam int HADR_W = 10;

  function automatic logic [HADR_W-1:0] port_base(input logic [1:0] p);
    logic [HADR_W-1:0] b;
    b = {1'b1, ~p[0], 8'hF8};
    if (p[1]) b = b - 10'h010;
    return b;
  endfunction

endpackage

// File: rtl/comdec_cfg_reg.sv
module comdec_cfg_reg
  import comdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [PIN_W-1:0] com_pins,
  output comdec_cfg_t      cfg_q,
  output logic [CFG_W-1:0] cfg_rdata
);

  comdec_cfg_t      cfg_d;
  logic [PIN_W-1:0] sync_q [SYNC_STAGES];
  logic [PIN_W-1:0] sync_d [SYNC_STAGES];

  always_comb begin
    cfg_d.dec_en   = cfg_wdata[0];
    cfg_d.force_cs = cfg_wdata[1];
    cfg_d.port     = cfg_wdata[4:3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  always_comb begin
    sync_d[0] = com_pins;
    for (int i = 1; i < SYNC_STAGES; i++) sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= sync_d[i];
    end
  end

  assign cfg_rdata = {1'b0, sync_q[SYNC_STAGES-1], cfg_q.port, 1'b0,
                      cfg_q.force_cs, cfg_q.dec_en};

  // R8: configuration holds without a write
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

  // R8: reserved read-back bits stay zero
  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] == 1'b0) && (cfg_rdata[2] == 1'b0));

  // R6: configuration is cleared when reset is released
  p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_q == '0));

endmodule

// File: rtl/comdec_match.sv
module comdec_match
  import comdec_pkg::*;
#(
  parameter int ADDR_HI = 9,
  parameter int ADDR_LO = 3,
  localparam int AW = ADDR_HI - ADDR_LO + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic        host_aen,
  input  logic        host_rd_n,
  input  logic        host_wr_n,
  input  logic        ext_cs_n,
  input  comdec_cfg_t cfg,
  output logic        mimic_sel,
  output logic        cs_out_n
);

  logic [HADR_W-1:0] base_full;
  logic [AW-1:0]     base_field;
  logic              addr_hit;
  logic              strobe;

  always_comb begin
    base_full  = port_base(cfg.port);
    base_field = base_full[ADDR_HI:ADDR_LO];
    addr_hit   = cfg.dec_en && !host_aen && (host_addr == base_field);
    strobe     = !host_rd_n || !host_wr_n;
    mimic_sel  = cfg.dec_en ? addr_hit : !ext_cs_n;
    cs_out_n   = !(addr_hit && cfg.force_cs && strobe);
  end

  // R1: decoded select implies the address equals the chosen base
  p_sel_on_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dec_en && mimic_sel) |-> (host_addr == port_base(cfg.port)[ADDR_HI:ADDR_LO]));

  // R3: forced chip select needs a host strobe
  p_cs_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_out_n |-> (!host_rd_n || !host_wr_n) && cfg.force_cs);

  // R4: mailbox space produces no select
  p_mailbox_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_aen |-> cs_out_n && !(cfg.dec_en && mimic_sel));

endmodule

// File: rtl/comdec_irq_route.sv
module comdec_irq_route
  import comdec_pkg::*;
#(
  parameter int NUM_PINS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  comdec_cfg_t         cfg,
  input  logic                mimic_irq,
  output logic [NUM_PINS-1:0] hint_o,
  output logic [NUM_PINS-1:0] hint_oe
);

  localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [SEL_W-1:0] pin_idx;

  always_comb begin
    pin_idx = '0;
    if (cfg.dec_en) pin_idx = SEL_W'(cfg.port[0]);
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_comb begin
      hint_oe[g] = (pin_idx == SEL_W'(g));
      hint_o[g]  = hint_oe[g] && mimic_irq;
    end
  end

  // R5: exactly one host interrupt pin is driven
  p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hint_oe) == 1);

  // R5: the driven pin follows the mimic interrupt
  p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_o != '0) == mimic_irq);

endmodule

// File: rtl/com_addr_decoder.sv
module com_addr_decoder
  import comdec_pkg::*;
#(
  parameter int ADDR_HI     = 9,
  parameter int ADDR_LO     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int AW = ADDR_HI - ADDR_LO + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    host_addr,
  input  logic             host_aen,
  input  logic             host_rd_n,
  input  logic             host_wr_n,
  input  logic             ext_cs_n,
  input  logic [1:0]       com_pins,
  input  logic             mimic_irq,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic             mimic_sel,
  output logic             cs_out_n,
  output logic [1:0]       hint_o,
  output logic [1:0]       hint_oe
);

  comdec_cfg_t cfg;

  comdec_cfg_reg #(.SYNC_STAGES(SYNC_STAGES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .com_pins  (com_pins),
    .cfg_q     (cfg),
    .cfg_rdata (cfg_rdata)
  );

  comdec_match #(.ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_aen  (host_aen),
    .host_rd_n (host_rd_n),
    .host_wr_n (host_wr_n),
    .ext_cs_n  (ext_cs_n),
    .cfg       (cfg),
    .mimic_sel (mimic_sel),
    .cs_out_n  (cs_out_n)
  );

  comdec_irq_route #(.NUM_PINS(2)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .mimic_irq (mimic_irq),
    .hint_o    (hint_o),
    .hint_oe   (hint_oe)
  );

  // R2: with decoding off the select mirrors the external chip select
  p_ext_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] |-> (mimic_sel == !ext_cs_n) && cs_out_n);

endmodule

// File: tb/com_addr_decoder_test.sv
module com_addr_decoder_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] host_addr;
  logic       host_aen, host_rd_n, host_wr_n, ext_cs_n, mimic_irq, cfg_we;
  logic [1:0] com_pins;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       mimic_sel, cs_out_n;
  logic [1:0] hint_o, hint_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  com_addr_decoder uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_aen(host_aen),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .ext_cs_n(ext_cs_n),
    .com_pins(com_pins), .mimic_irq(mimic_irq), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mimic_sel(mimic_sel),
    .cs_out_n(cs_out_n), .hint_o(hint_o), .hint_oe(hint_oe)
  );

  // reference model state
  bit       m_en = 0, m_force = 0;
  bit [1:0] m_port = 0, m_s1 = 0, m_s2 = 0;

  function automatic bit [9:0] ref_base(input bit [1:0] p);
    case (p)
      2'd0: return 10'h3F8;
      2'd1: return 10'h2F8;
      2'd2: return 10'h3E8;
      default: return 10'h2E8;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_force = 0; m_port = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = com_pins;
      if (cfg_we) begin
        m_en    = cfg_wdata[0];
        m_force = cfg_wdata[1];
        m_port  = cfg_wdata[4:3];
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    bit       hit, e_sel, e_cs;
    bit [9:0] b;
    bit [1:0] pin;
    b     = ref_base(m_port);
    hit   = m_en && !host_aen && (host_addr == b[9:3]);
    e_sel = m_en ? hit : !ext_cs_n;
    e_cs  = !(hit && m_force && (!host_rd_n || !host_wr_n));
    pin   = (m_en && m_port[0]) ? 2'b10 : 2'b01;
    chk("R1 mimic_sel", {7'd0, mimic_sel}, {7'd0, e_sel});
    chk("R3 cs_out_n", {7'd0, cs_out_n}, {7'd0, e_cs});
    chk("R5 hint_oe", {6'd0, hint_oe}, {6'd0, pin});
    chk("R5 hint_o", {6'd0, hint_o}, {6'd0, mimic_irq ? pin : 2'b00});
    chk("R7 cfg_rdata", cfg_rdata, {1'b0, m_s2, m_port, 1'b0, m_force, m_en});
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic settle_sample();
    @(negedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; host_addr = 7'h7F; host_aen = 1'b0; host_rd_n = 1'b1;
    host_wr_n = 1'b1; ext_cs_n = 1'b1; com_pins = 2'b00; mimic_irq = 1'b0;
    cfg_we = 1'b0; cfg_wdata = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    settle_sample();
    chk("R6 reset cfg", cfg_rdata, 8'h00);
    chk("R6 no decode after reset", {7'd0, mimic_sel}, 8'd0);

    // R2: decoding disabled, select follows external chip select
    ext_cs_n = 1'b0; host_rd_n = 1'b0;
    settle_sample();
    chk("R2 pass-through", {7'd0, mimic_sel}, 8'd1);
    chk("R2 no forced cs while disabled", {7'd0, cs_out_n}, 8'd1);
    host_rd_n = 1'b1;
    step();

    // walk every port with force on
    for (int p = 0; p < 4; p++) begin
      bit [9:0] b;
      b = ref_base(p[1:0]);
      wr_cfg({3'b000, p[1:0], 3'b011});
      host_addr = b[9:3]; ext_cs_n = 1'b1; mimic_irq = 1'b1;
      settle_sample();
      chk("R1 port match", {7'd0, mimic_sel}, 8'd1);
      chk("R5 pin select", {6'd0, hint_oe}, p[0] ? 8'd2 : 8'd1);
      host_wr_n = 1'b0;
      settle_sample();
      chk("R3 forced cs on write", {7'd0, cs_out_n}, 8'd0);
      host_aen = 1'b1;
      settle_sample();
      chk("R4 mailbox excluded", {7'd0, cs_out_n}, 8'd1);
      chk("R4 mailbox no select", {7'd0, mimic_sel}, 8'd0);
      host_aen = 1'b0; host_wr_n = 1'b1;
      host_addr = b[9:3] ^ 7'h02; ext_cs_n = 1'b0;
      settle_sample();
      chk("R2 ext cs ignored", {7'd0, mimic_sel}, 8'd0);
      ext_cs_n = 1'b1; mimic_irq = 1'b0;
      step();
    end

    // R8: reserved bits dropped, write visible next edge only
    host_addr = 7'h7F; host_rd_n = 1'b0;
    cfg_wdata = 8'hE5; cfg_we = 1'b1;
    settle_sample();
    chk("R8 not before edge", {7'd0, mimic_sel}, 8'd0);
    step();
    cfg_we = 1'b0;
    settle_sample();
    chk("R8 reserved bits", cfg_rdata & 8'h84, 8'h00);

    // same-cycle: config write during a live access on the old base
    wr_cfg(8'h0B);           // port 1, force, enable
    host_addr = 7'h5F; host_rd_n = 1'b0;
    cfg_wdata = 8'h13; cfg_we = 1'b1;   // port 2 written mid-access
    step();
    cfg_we = 1'b0;
    step();
    host_rd_n = 1'b1;

    // R7: pin readback delay
    com_pins = 2'b10;
    step();
    settle_sample();
    chk("R7 not yet synced", cfg_rdata[6:5], 8'd0);
    step();
    settle_sample();
    chk("R7 synced", {6'd0, cfg_rdata[6:5]}, 8'd2);

    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      bit [9:0] b;
      b = ref_base(2'($urandom_range(3)));
      host_addr = ($urandom_range(3) != 0) ? b[9:3] : 7'($urandom);
      host_aen  = ($urandom_range(5) == 0);
      host_rd_n = ($urandom_range(2) != 0);
      host_wr_n = ($urandom_range(2) != 0);
      ext_cs_n  = 1'($urandom);
      mimic_irq = 1'($urandom);
      com_pins  = 2'($urandom);
      cfg_we    = ($urandom_range(7) == 0);
      cfg_wdata = 8'($urandom);
      step();
    end
    cfg_we = 1'b0;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule